// File: doc/BRIEF.md
# Audio Bit-Clock and Frame-Clock Divider

This block turns a master audio clock into the two timing clocks that a serial audio link needs: a bit clock (`sclk`) and a left/right frame clock (`lrclk`). The master clock is the block's own clock input. The bit clock runs at one half or one quarter of the master rate. The frame clock is counted from falling edges of the bit clock only, and it is never taken straight from the master clock. Its period is 32, 64 or 128 bit-clock periods.

A single enable gates both outputs. While the enable is low, both clocks stay low and the divider settings are captured. When the enable rises, both counters start from zero with the captured settings. While the block runs, a new setting is held back until the next rising edge of the frame clock, so a frame already in progress always finishes at its original length. Two one-cycle strobes mark the bit-clock edges, so that downstream shift logic can work in the master-clock domain without detecting edges itself.

Top module: `audio_clk_divider`

## Requirements
- R1: With `bclk_div4` = 0 in force, `sclk` has a period of 2 master cycles and is high for 1 of them.
- R2: With `bclk_div4` = 1 in force, `sclk` has a period of 4 master cycles and is high for 2 of them.
- R3: With `frame_sel` code 01, 10 or 11 in force, `lrclk` has a period of 32, 64 or 128 `sclk` periods, with equal high and low halves.
- R4: While enabled, `lrclk` changes level only in a cycle where `sclk_fall` is high, which is a falling edge of `sclk`.
- R5: `sclk_rise` is high for exactly the cycles in which `sclk` has just gone from 0 to 1, and `sclk_fall` for exactly the cycles in which it has just gone from 1 to 0. The two strobes are never high together.
- R6: `frame_sel` code 00 is not a ratio. Loading it leaves the previously loaded frame ratio in force.
- R7: While running, changes on `bclk_div4` and `frame_sel` take effect only at the next rising edge of `lrclk`. The half-frames before that edge keep the old ratios.
- R8: While `en` is low, `sclk`, `lrclk` and both strobes are 0 from the first clock edge at which `en` is sampled low.
- R9: When `en` rises, counting restarts from zero with the settings present while disabled. `sclk` first rises at the 1st (div-2) or 2nd (div-4) enabled edge. `lrclk` first rises after one half-frame, which is half the frame ratio times the bit-clock period in master cycles.
- R10: A synchronous active-low reset drives every output to 0 and loads div-2 and the 64 frame ratio as the settings in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Shared run enable for both clocks |
| bclk_div4 | input | 1 | Bit-clock divide select: 0 gives master/2, 1 gives master/4 |
| frame_sel | input | 2 | Frame ratio code: 01 gives 32, 10 gives 64, 11 gives 128, 00 keeps the previous ratio |
| sclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame (left/right) clock |
| sclk_rise | output | 1 | One-cycle strobe on a rising edge of `sclk` |
| sclk_fall | output | 1 | One-cycle strobe on a falling edge of `sclk` |

## Verification
If the prescale phase is wrong, the spacing between `sclk_rise` strobes is wrong within one bit-clock period. A frame counter that is stuck or off by one shows as a wrong `lrclk` half-period as soon as the first half-frame completes after enable, which takes at most 256 master cycles. A ratio register that loads at the wrong time, or that accepts code 00, changes the length of the half-frame running when the new setting is applied, or of the one after it. The bench measures each of these lengths in master cycles and compares them against the ratios.

// File: rtl/audio_clk_pkg.sv
// Shared definitions for the audio bit/frame clock divider.
// Assumes frame ratios are fixed at 32, 64 and 128 bit clocks.
package audio_clk_pkg;

    typedef enum logic [1:0] {
        FRM_KEEP = 2'b00,
        FRM_32   = 2'b01,
        FRM_64   = 2'b10,
        FRM_128  = 2'b11
    } frame_code_e;

    localparam int unsigned MAX_FRAME_RATIO = 128;

    // Number of bit-clock falling edges in one half of a frame.
    function automatic int unsigned half_frame_edges(input logic [1:0] code);
        case (code)
            FRM_32:  half_frame_edges = 16;
            FRM_64:  half_frame_edges = 32;
            FRM_128: half_frame_edges = 64;
            default: half_frame_edges = 32;
        endcase
    endfunction

endpackage

// File: rtl/clk_ratio_hold.sv
// Holds the divider settings that are in force.
// Loads from the inputs while disabled, and at a frame rising boundary
// while running. A zero frame code never replaces the held frame ratio.
module clk_ratio_hold (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       boundary,
    input  logic       div4_in,
    input  logic [1:0] fsel_in,
    output logic       div4_act,
    output logic [1:0] fsel_act
);
    import audio_clk_pkg::*;

    logic load;
    assign load = !en || boundary;

    // Capture the settings at a legal load point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div4_act <= 1'b0;
            fsel_act <= FRM_64;
        end else if (load) begin
            div4_act <= div4_in;
            if (fsel_in != FRM_KEEP) fsel_act <= fsel_in;
        end
    end

    // R6: the frame ratio held is always one of the three legal codes.
    assert_legal_ratio_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fsel_act != FRM_KEEP);

    // R7: while running, held settings move only at a frame boundary.
    assert_hold_mid_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !boundary) |=> ($stable(div4_act) && $stable(fsel_act)));

endmodule

// File: rtl/bit_clock_gen.sv
// Divides the master clock by 2 or 4 into a 50% bit clock, with
// registered edge strobes. Exposes the upcoming falling edge as a
// combinational pulse for the frame counter.
// Assumes div4 changes only when a bit-clock edge is produced.
module bit_clock_gen #(
    parameter int PRE_W = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic div4,
    output logic sclk,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic fall_next
);
    logic [PRE_W-1:0] phase_q;
    logic             tick;

    assign tick      = div4 ? (phase_q == PRE_W'(1)) : 1'b1;
    assign fall_next = en && tick && sclk;

    // Advance the prescaler phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)   phase_q <= '0;
        else if (tick)       phase_q <= '0;
        else                 phase_q <= phase_q + PRE_W'(1);
    end

    // Toggle the bit clock and raise the matching strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sclk      <= 1'b0;
            sclk_rise <= 1'b0;
            sclk_fall <= 1'b0;
        end else begin
            sclk_rise <= tick && !sclk;
            sclk_fall <= tick && sclk;
            if (tick) sclk <= !sclk;
        end
    end

    // R5: strobes are exclusive.
    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_rise && sclk_fall));

    // R5: a rise strobe marks a real 0-to-1 step of the bit clock.
    assert_rise_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_rise) |-> (sclk && !$past(sclk)));

    // R8: disabled means the bit clock is low at the next edge.
    assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sclk && !sclk_rise && !sclk_fall));

endmodule

// File: rtl/frame_clock_gen.sv
// Counts bit-clock falling edges and toggles the frame clock every
// half frame. Flags the falling edge that will raise the frame clock,
// which is the only point where new settings may load.
module frame_clock_gen #(
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       fall_next,
    input  logic [1:0] fsel,
    output logic       lrclk,
    output logic       boundary
);
    import audio_clk_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   half_v;
    logic             terminal;

    assign half_v   = (CNT_W+1)'(half_frame_edges(fsel));
    assign terminal = ({1'b0, cnt_q} == (half_v - (CNT_W+1)'(1)));
    assign boundary = fall_next && terminal && !lrclk;

    // Count falling edges within the half frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)        cnt_q <= '0;
        else if (fall_next)       cnt_q <= terminal ? '0 : cnt_q + CNT_W'(1);
    end

    // Toggle the frame clock at the end of each half frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)                lrclk <= 1'b0;
        else if (fall_next && terminal)   lrclk <= !lrclk;
    end

    // R3: the edge counter never passes the half-frame length.
    assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt_q} < half_v));

    // R8: disabled means the frame clock is low at the next edge.
    assert_lr_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !lrclk);

endmodule

// File: rtl/audio_clk_divider.sv
// Top level: bit clock at master/2 or master/4, frame clock at
// 32/64/128 bit clocks, one shared enable, settings applied at the
// frame rising boundary. The master clock is the block clock.
module audio_clk_divider #(
    parameter int MAX_RATIO = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       bclk_div4,
    input  logic [1:0] frame_sel,
    output logic       sclk,
    output logic       lrclk,
    output logic       sclk_rise,
    output logic       sclk_fall
);
    localparam int CNT_W = $clog2(MAX_RATIO / 2);
    localparam int PRE_W = 1;

    logic       div4_act;
    logic [1:0] fsel_act;
    logic       fall_next;
    logic       boundary;

    clk_ratio_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .boundary (boundary),
        .div4_in  (bclk_div4),
        .fsel_in  (frame_sel),
        .div4_act (div4_act),
        .fsel_act (fsel_act)
    );

    bit_clock_gen #(.PRE_W(PRE_W)) u_bit (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .div4      (div4_act),
        .sclk      (sclk),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .fall_next (fall_next)
    );

    frame_clock_gen #(.CNT_W(CNT_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .fall_next (fall_next),
        .fsel      (fsel_act),
        .lrclk     (lrclk),
        .boundary  (boundary)
    );

    // R4: while running, the frame clock moves only with a bit-clock fall.
    assert_lr_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && (lrclk != $past(lrclk))) |-> sclk_fall);

endmodule

// File: tb/audio_clk_divider_tb_top.sv
module audio_clk_divider_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       bclk_div4 = 1'b0;
    logic [1:0] frame_sel = 2'b00;
    logic       sclk, lrclk, sclk_rise, sclk_fall;

    int checks = 0;
    int failures = 0;
    int strobe_err = 0;
    int lr_err = 0;
    int wd = 0;
    logic prev_s = 1'b0;
    logic prev_l = 1'b0;

    always #5 clk = !clk;

    audio_clk_divider dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .bclk_div4(bclk_div4),
        .frame_sel(frame_sel), .sclk(sclk), .lrclk(lrclk),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
    );

    // vector: div4, frame code, expected lrclk half period in master cycles
    localparam logic [15:0] VECS [0:5] = '{
        {1'b0, 2'b01, 13'd32},  {1'b0, 2'b10, 13'd64},  {1'b0, 2'b11, 13'd128},
        {1'b1, 2'b01, 13'd64},  {1'b1, 2'b10, 13'd128}, {1'b1, 2'b11, 13'd256}
    };

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One master cycle; tracks R4/R5 consistency while enabled.
    task automatic step();
        logic e;
        e = en;
        @(negedge clk);
        if (e) begin
            if ((sclk_rise != (sclk && !prev_s)) || (sclk_fall != (!sclk && prev_s)) ||
                (sclk_rise && sclk_fall)) strobe_err++;
            if ((lrclk != prev_l) && !sclk_fall) lr_err++;
        end
        prev_s = sclk;
        prev_l = lrclk;
    endtask

    task automatic wait_lr(input logic lvl, output int n);
        n = 0;
        do begin step(); n++; end while (lrclk != lvl && n < 3000);
    endtask

    task automatic sclk_period(output int per, output int hi);
        int n;
        n = 0;
        do begin step(); n++; end while (!sclk_rise && n < 100);
        per = 0; hi = 0;
        do begin step(); per++; if (sclk) hi++; end while (!sclk_rise && per < 100);
        if (sclk) hi--;
        hi++;
    endtask

    initial begin
        int n, hi, lo, per, shi;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check(!sclk && !lrclk && !sclk_rise && !sclk_fall, "R10 reset outputs", {sclk, lrclk}, 0);

        // R10: default ratio 64 and div-2 after reset with keep code.
        frame_sel = 2'b00; en = 1'b1;
        wait_lr(1'b1, n);
        check(n == 64, "R10 default half frame", n, 64);

        // Vector walk: R1 R2 R3 R9 and R4/R5 monitoring.
        for (int i = 0; i < 6; i++) begin
            en = 1'b0; bclk_div4 = VECS[i][15]; frame_sel = VECS[i][14:13];
            repeat (3) step();
            strobe_err = 0; lr_err = 0;
            en = 1'b1;
            step();
            check(sclk == !VECS[i][15], "R9 first sclk edge", sclk, !VECS[i][15]);
            n = 1;
            while (!lrclk && n < 3000) begin step(); n++; end
            check(n == int'(VECS[i][12:0]), "R9 first lrclk rise", n, VECS[i][12:0]);
            wait_lr(1'b0, hi);
            wait_lr(1'b1, lo);
            check(hi == int'(VECS[i][12:0]) && lo == hi, "R3 lrclk halves", hi*10000+lo, VECS[i][12:0]);
            sclk_period(per, shi);
            if (VECS[i][15])
                check(per == 4 && shi == 2, "R2 sclk div4", per*100+shi, 402);
            else
                check(per == 2 && shi == 1, "R1 sclk div2", per*100+shi, 201);
            check(strobe_err == 0, "R5 strobe consistency", strobe_err, 0);
            check(lr_err == 0, "R4 lrclk on sclk fall", lr_err, 0);
        end

        // R7: change mid frame; old ratio finishes both halves.
        en = 1'b0; bclk_div4 = 1'b0; frame_sel = 2'b01;
        repeat (3) step();
        en = 1'b1;
        wait_lr(1'b1, n);
        repeat (5) step();
        bclk_div4 = 1'b1; frame_sel = 2'b11;
        wait_lr(1'b0, hi);
        check(hi == 27, "R7 rest of high half", hi, 27);
        wait_lr(1'b1, lo);
        check(lo == 32, "R7 low half old ratio", lo, 32);
        wait_lr(1'b0, hi);
        check(hi == 256, "R7 new ratio after rise", hi, 256);

        // R6: keep code leaves the 128/div4 setting in force.
        frame_sel = 2'b00;
        wait_lr(1'b1, lo);
        wait_lr(1'b0, hi);
        check(hi == 256 && lo == 256, "R6 keep code", hi, 256);

        // R8: disable forces everything low.
        en = 1'b0;
        n = 0;
        for (int k = 0; k < 6; k++) begin
            step();
            if (sclk || lrclk || sclk_rise || sclk_fall) n++;
        end
        check(n == 0, "R8 idle outputs low", n, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule